// File: doc/BRIEF.md
# Issue-Stream Write Hazard Monitor

This block watches an in-order instruction issue stream, one instruction descriptor per clock. For every valid instruction it reports, one cycle later, whether issuing that instruction would create one of five non-RAW pipeline hazards that the compiler is expected to mitigate. It also reports which hazard was found. The block never stalls the stream and never inserts anything. It only observes and flags, so a code generator or a verification harness can point at the offending slot.

Each descriptor carries:
- an instruction class;
- one scalar register read and one scalar register write, each with its own valid bit;
- flags for an EXEC-mask write, a permute-lane operation, a no-op, a wait (with its counter kind and whether the count is zero), a non-clearing scalar ALU op and a branch;
- the instruction's byte offset;
- scalar buffer store/load flags with an address.

Four hazard rules need memory. Each of these rules is held by a small two-state tracker (TRK_IDLE, TRK_ARMED) with a stored key:
- a scalar register index for the memory-to-scalar rule;
- a scalar register index for the scalar-memory-to-vector rule;
- no key for the mask-compare-to-permute rule;
- a buffer address for the store-load alias rule.

Each tracker has three transitions:
- *arm*: from either state to TRK_ARMED, loading the new key. Arming overrides clearing.
- *clear*: from TRK_ARMED to TRK_IDLE.
- *hold*: the state and key stay as they are.

The branch-offset rule has no state. A priority encoder merges the five hit lines, and an output register presents the result.

Top module: `hzc_issue_monitor`

## Requirements
- R1: An instruction of class 5 (vector memory, flat, global or scratch) or class 6 (LDS) with `i_srd_vld` arms rule 1 on `i_srd`. A later class 0 (scalar ALU) or class 2 (scalar memory) instruction whose valid write `i_swr` equals that register is reported with code 1.
- R2: Rule 1 is cleared by any class 3 (VALU) or class 4 (VOPC) instruction, and by any instruction with `i_wait`=1. A class 1 (program-control) instruction without `i_wait`, or a class 0 instruction, does not clear it.
- R3: A class 2 instruction with `i_srd_vld` arms rule 2 on `i_srd`. A later class 3 or class 4 instruction whose valid write equals that register is reported with code 2.
- R4: Rule 2 is cleared in two ways. The first is a class 0 instruction with `i_salu_noclr`=0. The second is a class 1 instruction with `i_wait`=1 and `i_wait_lgkm`=1. It is not cleared by a class 0 instruction with `i_salu_noclr`=1, a wait with `i_wait_lgkm`=0, or a class 1 instruction without `i_wait`.
- R5: A class 4 instruction with `i_exec_wr`=1 arms rule 3. A later instruction with `i_permlane`=1 is reported with code 3. Any class 3 or class 4 instruction with `i_nop`=0 clears rule 3, unless that instruction re-arms it. A class 3 instruction with `i_nop`=1 leaves rule 3 armed.
- R6: A valid instruction with `i_branch`=1 whose `i_ofs[5:0]` equals 6'h3f is reported with code 4. Any other offset gives no rule-4 report.
- R7: A class 2 instruction with `i_sst`=1 arms rule 5 with `i_saddr`, and a newer store replaces the address. A later class 2 instruction with `i_sld`=1 at the same address is reported with code 5. Only a wait with `i_wait_lgkm`=1 and `i_wait_zero`=1 clears rule 5. No-ops and nonzero waits do not clear it.
- R8: When several rules match, the lowest nonzero code is reported. `o_hz` is 1 exactly when `o_vld`=1 and `o_code` is nonzero. Codes are 0 none, 1 memory-to-scalar, 2 scalar-memory-to-vector, 3 mask-compare-to-permute, 4 branch offset, 5 store-load alias.
- R9: For rules 1 and 2, a new arming event replaces the held register. An instruction that is flagged does not disarm its rule.
- R10: The result for the instruction presented at a rising edge appears on `o_vld`/`o_hz`/`o_code` just after that edge. A cycle with `i_vld`=0 arms nothing, clears nothing and yields `o_vld`=0 and `o_code`=0.
- R11: Synchronous reset (`rst`=1) returns every tracker to TRK_IDLE and zeroes the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| i_vld | input | 1 | Descriptor valid |
| i_cls | input | 3 | Instruction class (0 SALU, 1 program-control, 2 SMEM, 3 VALU, 4 VOPC, 5 VMEM/flat/global/scratch, 6 LDS, 7 other) |
| i_srd_vld | input | 1 | Scalar read valid |
| i_srd | input | SREG_W | Scalar register read |
| i_swr_vld | input | 1 | Scalar write valid |
| i_swr | input | SREG_W | Scalar register written |
| i_exec_wr | input | 1 | Instruction writes EXEC |
| i_permlane | input | 1 | Permute-lane instruction |
| i_nop | input | 1 | No-op of its class |
| i_wait | input | 1 | Wait-counter instruction |
| i_wait_lgkm | input | 1 | Wait targets the scalar-memory/LDS counter |
| i_wait_zero | input | 1 | Wait count is zero |
| i_salu_noclr | input | 1 | Scalar ALU op that does not clear rule 2 |
| i_branch | input | 1 | Branch instruction |
| i_ofs | input | OFS_W | Byte offset of the instruction |
| i_sst | input | 1 | Scalar buffer store |
| i_sld | input | 1 | Scalar buffer load |
| i_saddr | input | ADDR_W | Scalar buffer address |
| o_vld | output | 1 | Result valid |
| o_hz | output | 1 | Hazard found |
| o_code | output | 3 | Hazard code |

## Verification
The bench builds the monitor with SREG_W=3, ADDR_W=4 and OFS_W=8. The small widths make full sweeps practical:
- every arm/probe register pair of rules 1 and 2 (64 each);
- every store/load address pair of rule 5 (256);
- all 256 instruction offsets, both as branches and as non-branches.

The expected code is computed from index equality and the offset bits. Directed sequences cover each rule's clearing and non-clearing instructions, replacement of the held key, priority between rules that hit together, idle slots and reset.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

    typedef enum logic [2:0] {
        CLS_SALU = 3'd0,
        CLS_SOPP = 3'd1,
        CLS_SMEM = 3'd2,
        CLS_VALU = 3'd3,
        CLS_VOPC = 3'd4,
        CLS_VMEM = 3'd5,
        CLS_LDS  = 3'd6,
        CLS_MISC = 3'd7
    } cls_e;

    typedef enum logic [2:0] {
        HZ_NONE        = 3'd0,
        HZ_MEM_SCALAR  = 3'd1,
        HZ_SMEM_VECTOR = 3'd2,
        HZ_EXEC_PERM   = 3'd3,
        HZ_BRANCH_OFS  = 3'd4,
        HZ_ST_LD       = 3'd5
    } hz_e;

    localparam int          NUM_RULES   = 5;
    localparam int          CODE_W      = 3;
    localparam int          OFS_LOW_W   = 6;
    localparam logic [5:0]  BAD_OFS_LOW = 6'h3f;

endpackage

// File: rtl/hzc_tracker.sv
module hzc_tracker #(
    parameter int KEY_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [KEY_W-1:0] arm_key,
    input  logic             clr,
    input  logic             probe,
    input  logic [KEY_W-1:0] probe_key,
    output logic             hit
);

    typedef enum logic {
        TRK_IDLE  = 1'b0,
        TRK_ARMED = 1'b1
    } trk_e;

    trk_e             state, state_nxt;
    logic [KEY_W-1:0] key, key_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TRK_IDLE;
            key   <= '0;
        end else begin
            state <= state_nxt;
            key   <= key_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        key_nxt   = key;
        unique case (state)
            TRK_IDLE: begin
                if (arm) begin
                    state_nxt = TRK_ARMED;
                    key_nxt   = arm_key;
                end
            end
            TRK_ARMED: begin
                if (arm) begin
                    key_nxt = arm_key;
                end else if (clr) begin
                    state_nxt = TRK_IDLE;
                end
            end
            default: state_nxt = TRK_IDLE;
        endcase
    end

    always_comb begin
        hit = 1'b0;
        unique case (state)
            TRK_IDLE:  hit = 1'b0;
            TRK_ARMED: hit = probe && (key == probe_key);
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/hzc_prio.sv
module hzc_prio #(
    parameter int N      = 5,
    parameter int CODE_W = 3
) (
    input  logic [N-1:0]      hits,
    output logic [CODE_W-1:0] code
);

    always_comb begin
        code = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (hits[k]) code = CODE_W'(k + 1);
        end
    end

endmodule

// File: rtl/hzc_issue_monitor.sv
module hzc_issue_monitor
    import hzc_pkg::*;
#(
    parameter int SREG_W = 7,
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              i_vld,
    input  logic [2:0]        i_cls,
    input  logic              i_srd_vld,
    input  logic [SREG_W-1:0] i_srd,
    input  logic              i_swr_vld,
    input  logic [SREG_W-1:0] i_swr,
    input  logic              i_exec_wr,
    input  logic              i_permlane,
    input  logic              i_nop,
    input  logic              i_wait,
    input  logic              i_wait_lgkm,
    input  logic              i_wait_zero,
    input  logic              i_salu_noclr,
    input  logic              i_branch,
    input  logic [OFS_W-1:0]  i_ofs,
    input  logic              i_sst,
    input  logic              i_sld,
    input  logic [ADDR_W-1:0] i_saddr,
    output logic              o_vld,
    output logic              o_hz,
    output logic [2:0]        o_code
);

    cls_e cls;
    logic is_salu, is_sopp, is_smem, is_vector, is_vmem_like;
    assign cls          = cls_e'(i_cls);
    assign is_salu      = i_vld && (cls == CLS_SALU);
    assign is_sopp      = i_vld && (cls == CLS_SOPP);
    assign is_smem      = i_vld && (cls == CLS_SMEM);
    assign is_vector    = i_vld && ((cls == CLS_VALU) || (cls == CLS_VOPC));
    assign is_vmem_like = i_vld && ((cls == CLS_VMEM) || (cls == CLS_LDS));

    logic [NUM_RULES-1:0] hits;
    logic                 perm_arm;

    // rule 1: memory read of scalar, then scalar write
    hzc_tracker #(.KEY_W(SREG_W)) u_mem_scalar (
        .clk       (clk),
        .rst       (rst),
        .arm       (is_vmem_like && i_srd_vld),
        .arm_key   (i_srd),
        .clr       (is_vector || (i_vld && i_wait)),
        .probe     ((is_salu || is_smem) && i_swr_vld),
        .probe_key (i_swr),
        .hit       (hits[0])
    );

    // rule 2: scalar memory read, then vector write
    hzc_tracker #(.KEY_W(SREG_W)) u_smem_vector (
        .clk       (clk),
        .rst       (rst),
        .arm       (is_smem && i_srd_vld),
        .arm_key   (i_srd),
        .clr       ((is_salu && !i_salu_noclr) || (is_sopp && i_wait && i_wait_lgkm)),
        .probe     (is_vector && i_swr_vld),
        .probe_key (i_swr),
        .hit       (hits[1])
    );

    // rule 3: mask compare writing EXEC, then permute
    assign perm_arm = i_vld && (cls == CLS_VOPC) && i_exec_wr;
    hzc_tracker #(.KEY_W(1)) u_exec_perm (
        .clk       (clk),
        .rst       (rst),
        .arm       (perm_arm),
        .arm_key   (1'b0),
        .clr       (is_vector && !i_nop),
        .probe     (i_vld && i_permlane),
        .probe_key (1'b0),
        .hit       (hits[2])
    );

    // rule 4: branch at a bad offset (stateless)
    assign hits[3] = i_vld && i_branch && (i_ofs[OFS_LOW_W-1:0] == BAD_OFS_LOW);

    // rule 5: scalar buffer store, then load of the same address
    hzc_tracker #(.KEY_W(ADDR_W)) u_st_ld (
        .clk       (clk),
        .rst       (rst),
        .arm       (is_smem && i_sst),
        .arm_key   (i_saddr),
        .clr       (i_vld && i_wait && i_wait_lgkm && i_wait_zero),
        .probe     (is_smem && i_sld),
        .probe_key (i_saddr),
        .hit       (hits[4])
    );

    logic [CODE_W-1:0] code_c;
    hzc_prio #(.N(NUM_RULES), .CODE_W(CODE_W)) u_prio (
        .hits (hits),
        .code (code_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            o_vld  <= 1'b0;
            o_hz   <= 1'b0;
            o_code <= HZ_NONE;
        end else begin
            o_vld  <= i_vld;
            o_hz   <= i_vld && (code_c != '0);
            o_code <= i_vld ? code_c : HZ_NONE;
        end
    end

endmodule

// File: rtl/hzc_checker.sv
module hzc_checker #(
    parameter int OFS_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             i_vld,
    input logic             i_branch,
    input logic [OFS_W-1:0] i_ofs,
    input logic             o_vld,
    input logic             o_hz,
    input logic [2:0]       o_code
);

    p_flag_code_r8: assert property (@(posedge clk) disable iff (rst)
        o_hz == (o_vld && (o_code != 3'd0)));

    p_code_range_r8: assert property (@(posedge clk) disable iff (rst)
        o_code <= 3'd5);

    p_bubble_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !i_vld |=> (!o_vld && (o_code == 3'd0)));

    p_branch_ofs_r6: assert property (@(posedge clk) disable iff (rst)
        (i_vld && i_branch && (i_ofs[5:0] == 6'h3f)) |=>
            (o_vld && (o_code != 3'd0) && (o_code <= 3'd4)));

    p_reset_out_r11: assert property (@(posedge clk)
        $past(rst) |-> (!o_vld && !o_hz));

endmodule

bind hzc_issue_monitor hzc_checker #(.OFS_W(OFS_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .i_vld    (i_vld),
    .i_branch (i_branch),
    .i_ofs    (i_ofs),
    .o_vld    (o_vld),
    .o_hz     (o_hz),
    .o_code   (o_code)
);

// File: tb/sim_hzc_issue_monitor.sv
`timescale 1ns/1ps
module sim_hzc_issue_monitor;

    localparam int SREG_W = 3;
    localparam int ADDR_W = 4;
    localparam int OFS_W  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              i_vld, i_srd_vld, i_swr_vld, i_exec_wr, i_permlane, i_nop;
    logic              i_wait, i_wait_lgkm, i_wait_zero, i_salu_noclr, i_branch, i_sst, i_sld;
    logic [2:0]        i_cls;
    logic [SREG_W-1:0] i_srd, i_swr;
    logic [OFS_W-1:0]  i_ofs;
    logic [ADDR_W-1:0] i_saddr;
    logic              o_vld, o_hz;
    logic [2:0]        o_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    hzc_issue_monitor #(.SREG_W(SREG_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W)) u0 (.*);

    task automatic blank();
        i_vld = 0; i_cls = 3'd7; i_srd_vld = 0; i_srd = '0; i_swr_vld = 0; i_swr = '0;
        i_exec_wr = 0; i_permlane = 0; i_nop = 0; i_wait = 0; i_wait_lgkm = 0;
        i_wait_zero = 0; i_salu_noclr = 0; i_branch = 0; i_ofs = '0;
        i_sst = 0; i_sld = 0; i_saddr = '0;
    endtask

    task automatic step();
        @(posedge clk); #1;
        blank();
    endtask

    task automatic start(input logic [2:0] c);
        blank(); i_vld = 1; i_cls = c;
    endtask

    task automatic do_reset();
        blank(); rst = 1;
        @(posedge clk); @(posedge clk); #1;
        rst = 0;
    endtask

    task automatic check(input logic [2:0] exp, input string tag);
        n_chk++;
        if (o_vld !== 1'b1 || o_code !== exp || o_hz !== (exp != 3'd0)) begin
            n_bad++;
            $display("FAIL %s: vld=%0b hz=%0b code=%0d expected vld=1 hz=%0b code=%0d",
                     tag, o_vld, o_hz, o_code, exp != 3'd0, exp);
        end
    endtask

    // instruction helpers
    task automatic mem_rd(input logic [2:0] c, input int r);
        start(c); i_srd_vld = 1; i_srd = SREG_W'(r); step(); endtask
    task automatic wr(input logic [2:0] c, input int r);
        start(c); i_swr_vld = 1; i_swr = SREG_W'(r); step(); endtask
    task automatic plain(input logic [2:0] c);
        start(c); step(); endtask
    task automatic salu_nc();
        start(3'd0); i_salu_noclr = 1; step(); endtask
    task automatic vnop();
        start(3'd3); i_nop = 1; step(); endtask
    task automatic waitc(input bit lg, input bit z);
        start(3'd1); i_wait = 1; i_wait_lgkm = lg; i_wait_zero = z; step(); endtask
    task automatic vopc_exec();
        start(3'd4); i_exec_wr = 1; step(); endtask
    task automatic perm();
        start(3'd3); i_permlane = 1; step(); endtask
    task automatic sst(input int a);
        start(3'd2); i_sst = 1; i_saddr = ADDR_W'(a); step(); endtask
    task automatic sld(input int a);
        start(3'd2); i_sld = 1; i_saddr = ADDR_W'(a); step(); endtask

    initial begin
        blank();
        do_reset();
        n_chk++;
        if (o_vld !== 0 || o_hz !== 0 || o_code !== 0) begin
            n_bad++;
            $display("FAIL R11 reset outputs: vld=%0b hz=%0b code=%0d expected 0 0 0", o_vld, o_hz, o_code);
        end

        // R1 sweep: arm class 5/6, probe class 0/2
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                do_reset();
                mem_rd((b % 2) ? 3'd6 : 3'd5, a); check(3'd0, "R1 arm slot");
                wr((a % 2) ? 3'd2 : 3'd0, b);     check((a == b) ? 3'd1 : 3'd0, "R1 scalar write");
            end
        end

        // R2 clearing and non-clearing
        do_reset(); mem_rd(3'd5, 2); plain(3'd3); wr(3'd0, 2); check(3'd0, "R2 VALU clears");
        do_reset(); mem_rd(3'd5, 2); plain(3'd4); wr(3'd0, 2); check(3'd0, "R2 VOPC clears");
        do_reset(); mem_rd(3'd6, 2); waitc(0, 0); wr(3'd0, 2); check(3'd0, "R2 any wait clears");
        do_reset(); mem_rd(3'd6, 2); plain(3'd1); wr(3'd2, 2); check(3'd1, "R2 program-control nop keeps");
        do_reset(); mem_rd(3'd5, 2); plain(3'd0); wr(3'd0, 2); check(3'd1, "R2 SALU keeps");

        // R3 sweep
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                do_reset();
                mem_rd(3'd2, a);
                wr((b % 2) ? 3'd4 : 3'd3, b); check((a == b) ? 3'd2 : 3'd0, "R3 vector write");
            end
        end

        // R4
        do_reset(); mem_rd(3'd2, 5); plain(3'd0);  wr(3'd3, 5); check(3'd0, "R4 SALU clears");
        do_reset(); mem_rd(3'd2, 5); salu_nc();    wr(3'd3, 5); check(3'd2, "R4 noclr SALU keeps");
        do_reset(); mem_rd(3'd2, 5); waitc(0, 1);  wr(3'd3, 5); check(3'd2, "R4 non-lgkm wait keeps");
        do_reset(); mem_rd(3'd2, 5); waitc(1, 0);  wr(3'd3, 5); check(3'd0, "R4 lgkm wait clears");
        do_reset(); mem_rd(3'd2, 5); plain(3'd1);  wr(3'd3, 5); check(3'd2, "R4 plain program-control keeps");

        // R5
        do_reset(); vopc_exec(); check(3'd0, "R5 arm slot"); perm(); check(3'd3, "R5 permute flagged");
        perm(); check(3'd0, "R5 permute itself clears");
        do_reset(); vopc_exec(); vnop(); perm(); check(3'd3, "R5 v_nop keeps");
        do_reset(); vopc_exec(); plain(3'd3); perm(); check(3'd0, "R5 VALU clears");
        do_reset(); plain(3'd4); perm(); check(3'd0, "R5 VOPC w/o exec no arm");
        do_reset(); vopc_exec(); plain(3'd0); plain(3'd2); perm(); check(3'd3, "R5 scalar ops keep");

        // R6 offsets
        do_reset();
        for (int o = 0; o < 256; o++) begin
            start(3'd1); i_branch = 1; i_ofs = OFS_W'(o); step();
            check(((o % 64) == 63) ? 3'd4 : 3'd0, "R6 branch offset");
            start(3'd1); i_ofs = OFS_W'(o); step();
            check(3'd0, "R6 non-branch offset");
        end

        // R7 sweep
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                do_reset();
                sst(a); sld(b); check((a == b) ? 3'd5 : 3'd0, "R7 alias");
            end
        end
        do_reset(); sst(9); plain(3'd1);  sld(9); check(3'd5, "R7 nop keeps");
        do_reset(); sst(9); waitc(1, 0);  sld(9); check(3'd5, "R7 nonzero wait keeps");
        do_reset(); sst(9); waitc(0, 1);  sld(9); check(3'd5, "R7 non-lgkm zero wait keeps");
        do_reset(); sst(9); waitc(1, 1);  sld(9); check(3'd0, "R7 lgkm zero clears");
        do_reset(); sst(9); sst(4); sld(9); check(3'd0, "R7 newer store replaces old");
        sld(4); check(3'd5, "R7 newer store address");

        // R8 priority
        do_reset(); mem_rd(3'd5, 3); sst(7);
        start(3'd2); i_sld = 1; i_saddr = 4'd7; i_swr_vld = 1; i_swr = 3'd3; step();
        check(3'd1, "R8 rule1 over rule5");
        do_reset(); mem_rd(3'd2, 6); vopc_exec();
        start(3'd3); i_permlane = 1; i_swr_vld = 1; i_swr = 3'd6; step();
        check(3'd2, "R8 rule2 over rule3");
        do_reset(); sst(11);
        start(3'd2); i_sld = 1; i_saddr = 4'd11; i_branch = 1; i_ofs = 8'hbf; step();
        check(3'd4, "R8 rule4 over rule5");

        // R9 replacement and persistence
        do_reset(); mem_rd(3'd5, 1); mem_rd(3'd6, 4);
        wr(3'd0, 1); check(3'd0, "R9 old reg replaced");
        wr(3'd0, 4); check(3'd1, "R9 new reg flagged");
        wr(3'd2, 4); check(3'd1, "R9 flag does not disarm");
        do_reset(); mem_rd(3'd2, 0); mem_rd(3'd2, 7);
        wr(3'd3, 0); check(3'd0, "R9 rule2 old reg replaced");
        wr(3'd3, 7); check(3'd2, "R9 rule2 new reg");

        // R10 bubbles
        do_reset(); mem_rd(3'd5, 2);
        blank(); i_cls = 3'd3; step();
        n_chk++;
        if (o_vld !== 0 || o_code !== 0 || o_hz !== 0) begin
            n_bad++;
            $display("FAIL R10 bubble: vld=%0b hz=%0b code=%0d expected 0 0 0", o_vld, o_hz, o_code);
        end
        wr(3'd0, 2); check(3'd1, "R10 bubble does not clear");
        blank(); i_cls = 3'd2; i_sst = 1; i_saddr = 4'd3; step();
        sld(3); check(3'd0, "R10 bubble does not arm");

        // R11 reset clears armed state
        do_reset(); mem_rd(3'd5, 1); mem_rd(3'd2, 2); vopc_exec(); sst(5);
        do_reset();
        wr(3'd0, 1); check(3'd0, "R11 rule1 cleared");
        wr(3'd3, 2); check(3'd0, "R11 rule2 cleared");
        perm();      check(3'd0, "R11 rule3 cleared");
        sld(5);      check(3'd0, "R11 rule5 cleared");

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule